// File: doc/BRIEF.md
# Phase-Shifted PWM Timer with Shadowed Compares

This block is a free-running up-counter that drives two PWM outputs from one time base. The first output is edge-aligned against a single compare value. The second output is a paired output whose rising and falling edges each come from their own compare value, so its phase can be slid against the first output. Both outputs share one counter, and that counter is never stopped or reset to change a compare value. The relative phase of the two outputs therefore stays locked while the paired edges move.

Software reaches the block through a simple register write port. While the counter runs, compare and modulus writes land in shadow copies. The shadow copies move into the live registers together on the cycle where the counter wraps from the modulus back to zero. An arm bit in the control register holds back the paired compares, so software can stage both halves of a new pair before either one takes effect. While the counter is stopped, writes go straight to the live registers.

Top module: `pwm_phase_timer`

## Requirements
- R1: While running (control address 0, bit 0 set), the count rises by one per clock and returns to 0 on the clock after it equals the live modulus, which gives a period of modulus plus one clocks. The count is 0 after reset.
- R2: While the run bit is clear, the count holds its value.
- R3: A write to address 5 (data ignored) forces the count to 0 on the next clock, taking priority over counting.
- R4: The single-edge output is low while the count is below the live single compare (address 2) and high from that value through the modulus.
- R5: The paired output is high while the count is at least the live rise compare (address 3) and below the live fall compare (address 4). It stays low for the whole period when rise is greater than or equal to fall.
- R6: While running, writes to addresses 2, 3 and 4 leave the outputs unchanged for the rest of the current period. The staged values take effect together from count 0 of the next period.
- R7: While stopped, a write to address 1, 2, 3 or 4 sets the live value on the next clock.
- R8: While the arm bit (address 0, bit 1) is clear, staged rise and fall values are not transferred at a wrap. The modulus and the single compare still transfer.
- R9: A modulus write (address 1) while running does not end the current period early. It becomes the live modulus from the next wrap.
- R10: A buffered write that is sampled on the same clock as a wrap is not used by that wrap. It takes effect at the following wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 modulus, 2 single compare, 3 rise, 4 fall, 5 count clear) |
| wr_data | input | CNT_W | Write data |
| count_o | output | CNT_W | Current count |
| solo_pwm | output | 1 | Edge-aligned single-compare output |
| pair_pwm | output | 1 | Paired output with rise and fall edges |

## Verification
A register write and the counter wrap can land on the same clock edge. In that case the transfer must use the shadow contents from before the write, and the write is held until the next wrap. The bench forces this by waiting until the count equals the modulus and issuing the write at that moment. It then checks the single-edge output at a count that separates the old compare from the new one, first in the next period and again in the period after. A count-clear write is also aimed at a running count, and a cycle-by-cycle reference model judges every edge.

// File: rtl/ptmr_pkg.sv
// Shared definitions for the phase-shifted PWM timer.
// Assumes a 3-bit register address on the write port.
package ptmr_pkg;
    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_MOD  = 3'd1,
        A_SOLO = 3'd2,
        A_RISE = 3'd3,
        A_FALL = 3'd4,
        A_CLR  = 3'd5
    } ptmr_addr_e;

    // index of each shadowed register in the shadow bank
    localparam int SH_MOD  = 0;
    localparam int SH_SOLO = 1;
    localparam int SH_RISE = 2;
    localparam int SH_FALL = 3;
    localparam int SH_NUM  = 4;
endpackage

// File: rtl/ptmr_counter.sv
// Up-counter from 0 to the live modulus, then back to 0.
// Assumes clear has priority over counting; wrap is flagged combinationally
// in the cycle whose edge returns the count to 0. A count above the modulus
// (modulus lowered while stopped) also wraps.
module ptmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [CNT_W-1:0] modulus,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    // end of period reached while running
    always_comb wrap = run && (count >= modulus);

    // count register with clear, wrap and increment
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (clear)  count <= '0;
        else if (wrap)   count <= '0;
        else if (run)    count <= count + 1'b1;
    end
endmodule

// File: rtl/ptmr_shadow.sv
// One shadowed register: a staging copy plus a live copy.
// direct: write reaches the live copy at once (timer stopped).
// load: live copy takes the staging copy as it stood before this edge,
// so a write in the same cycle waits for the next load.
module ptmr_shadow #(
    parameter int               W   = 16,
    parameter logic [W-1:0]     RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         direct,
    input  logic         load,
    output logic [W-1:0] active
);
    logic [W-1:0] stage_q;

    // staging copy follows every write
    always_ff @(posedge clk) begin
        if (!rst_n)  stage_q <= RST;
        else if (wr) stage_q <= wdata;
    end

    // live copy: direct write when stopped, else transfer on load
    always_ff @(posedge clk) begin
        if (!rst_n)             active <= RST;
        else if (wr && direct)  active <= wdata;
        else if (load)          active <= stage_q;
    end
endmodule

// File: rtl/ptmr_outputs.sv
// Output decode from the count and the live compare values.
// Single-edge output is high from its compare through the modulus; the
// paired output is high on [rise, fall) and low when rise >= fall.
module ptmr_outputs #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] solo_cmp,
    input  logic [CNT_W-1:0] rise_cmp,
    input  logic [CNT_W-1:0] fall_cmp,
    output logic             solo_pwm,
    output logic             pair_pwm
);
    logic pair_valid;

    // edge-aligned single output
    always_comb solo_pwm = (count >= solo_cmp);

    // paired window, suppressed for an empty or inverted window
    always_comb begin
        pair_valid = (rise_cmp < fall_cmp);
        pair_pwm   = pair_valid && (count >= rise_cmp) && (count < fall_cmp);
    end
endmodule

// File: rtl/pwm_phase_timer.sv
// Top level: write decode, control bits, shadow bank, counter and outputs.
// Assumes writes are single-cycle strobes; the control register takes
// effect on the next clock; reset leaves the timer stopped and armed.
module pwm_phase_timer #(
    parameter int               CNT_W   = 16,
    parameter logic [CNT_W-1:0] DEF_MOD = CNT_W'(1499)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             solo_pwm,
    output logic             pair_pwm
);
    import ptmr_pkg::*;

    logic             run_q;
    logic             arm_q;
    logic             wrap;
    logic             clr_wr;
    logic [CNT_W-1:0] act [SH_NUM];
    logic [CNT_W-1:0] mod_act;
    logic [CNT_W-1:0] solo_act;
    logic [CNT_W-1:0] rise_act;
    logic [CNT_W-1:0] fall_act;

    // count clear strobe
    always_comb clr_wr = wr_en && (wr_addr == A_CLR);

    // control register: run and pair arm
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            arm_q <= 1'b1;
        end else if (wr_en && (wr_addr == A_CTRL)) begin
            run_q <= wr_data[0];
            arm_q <= wr_data[1];
        end
    end

    // shadow bank: modulus, single compare, rise, fall
    for (genvar i = 0; i < SH_NUM; i++) begin : g_sh
        localparam logic [CNT_W-1:0] RV   = (i == SH_MOD) ? DEF_MOD : '0;
        localparam logic [2:0]       ADDR = 3'(i + 1);
        localparam bit               PAIR = (i == SH_RISE) || (i == SH_FALL);
        logic ld;
        // pair members also wait for the arm bit
        always_comb ld = PAIR ? (wrap && arm_q) : wrap;
        ptmr_shadow #(.W(CNT_W), .RST(RV)) u_sh (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (wr_en && (wr_addr == ADDR)),
            .wdata  (wr_data),
            .direct (!run_q),
            .load   (ld),
            .active (act[i])
        );
    end

    // named views of the live values
    always_comb begin
        mod_act  = act[SH_MOD];
        solo_act = act[SH_SOLO];
        rise_act = act[SH_RISE];
        fall_act = act[SH_FALL];
    end

    ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .clear   (clr_wr),
        .modulus (mod_act),
        .count   (count_o),
        .wrap    (wrap)
    );

    ptmr_outputs #(.CNT_W(CNT_W)) u_out (
        .count    (count_o),
        .solo_cmp (solo_act),
        .rise_cmp (rise_act),
        .fall_cmp (fall_act),
        .solo_pwm (solo_pwm),
        .pair_pwm (pair_pwm)
    );
endmodule

// File: rtl/pwm_phase_timer_chk.sv
// Property checker bound into the timer top; observes ports and live state.
module pwm_phase_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [CNT_W-1:0] count,
    input logic             run,
    input logic             arm,
    input logic [CNT_W-1:0] mod_act,
    input logic [CNT_W-1:0] solo_act,
    input logic [CNT_W-1:0] rise_act,
    input logic [CNT_W-1:0] fall_act,
    input logic             pair_pwm
);
    logic clr;
    always_comb clr = wr_en && (wr_addr == 3'd5);

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && (count < mod_act)) |=> (count == $past(count) + 1'b1));

    // R1
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (count >= mod_act)) |=> (count == '0));

    // R2
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(count));

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R5
    empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_act >= fall_act) |-> !pair_pwm);

    // R6
    live_mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (count < mod_act)) |=>
            ($stable(solo_act) && $stable(rise_act) && $stable(fall_act) && $stable(mod_act)));

    // R8
    pair_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !arm) |=> ($stable(rise_act) && $stable(fall_act)));
endmodule

bind pwm_phase_timer pwm_phase_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .count    (count_o),
    .run      (run_q),
    .arm      (arm_q),
    .mod_act  (mod_act),
    .solo_act (solo_act),
    .rise_act (rise_act),
    .fall_act (fall_act),
    .pair_pwm (pair_pwm)
);

// File: tb/pwm_phase_timer_tb.sv
module pwm_phase_timer_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count_o;
    logic         solo_pwm;
    logic         pair_pwm;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt, m_mod, m_solo, m_rise, m_fall;
    int b_mod, b_solo, b_rise, b_fall;
    bit m_run, m_arm;

    // phase-lock tracker
    bit lock_on = 0;
    bit have_last = 0;
    bit prev_solo = 0;
    int last_rise = 0;

    always #4 clk = ~clk;

    pwm_phase_timer #(.CNT_W(W), .DEF_MOD(16'd1499)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_o(count_o), .solo_pwm(solo_pwm), .pair_pwm(pair_pwm)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // reference model update on each edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_mod = 1499; m_solo = 0; m_rise = 0; m_fall = 0;
            b_mod = 1499; b_solo = 0; b_rise = 0; b_fall = 0;
            m_run = 0; m_arm = 1;
        end else begin
            bit was_run;
            bit wrp;
            bit clr;
            was_run = m_run;
            wrp = m_run && (m_cnt >= m_mod);
            clr = wr_en && (wr_addr == 3'd5);
            if (clr) m_cnt = 0;
            else if (wrp) m_cnt = 0;
            else if (m_run) m_cnt = m_cnt + 1;
            if (wrp) begin
                m_mod = b_mod; m_solo = b_solo;
                if (m_arm) begin m_rise = b_rise; m_fall = b_fall; end
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_run = wr_data[0]; m_arm = wr_data[1]; end
                    3'd1: begin b_mod = wr_data; if (!was_run) m_mod = wr_data; end
                    3'd2: begin b_solo = wr_data; if (!was_run) m_solo = wr_data; end
                    3'd3: begin b_rise = wr_data; if (!was_run) m_rise = wr_data; end
                    3'd4: begin b_fall = wr_data; if (!was_run) m_fall = wr_data; end
                    default: ;
                endcase
            end
        end
    end

    // compare against the model every cycle, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            int es;
            int ep;
            es = (m_cnt >= m_solo) ? 1 : 0;
            ep = (m_rise < m_fall && m_cnt >= m_rise && m_cnt < m_fall) ? 1 : 0;
            chk({cur_req, " model count"}, int'(count_o), m_cnt);
            chk({cur_req, " model solo"}, int'(solo_pwm), es);
            chk({cur_req, " model pair"}, int'(pair_pwm), ep);
            // R1 phase lock: single-edge rises exactly one period apart
            if (solo_pwm && !prev_solo) begin
                if (lock_on && have_last) chk("R1 solo period", cyc - last_rise, 40);
                last_rise = cyc;
                have_last = 1;
            end
            prev_solo = solo_pwm;
        end
    end

    // watchdog
    initial begin
        #200000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic wr(input logic [2:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_count(input int v);
        @(negedge clk);
        while (int'(count_o) != v) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state
        chk("R1 reset count", int'(count_o), 0);
        chk("R5 reset pair", int'(pair_pwm), 0);
        chk("R4 reset solo", int'(solo_pwm), 1);

        // R7: stopped writes are immediate
        cur_req = "R7";
        wr(3'd1, 39);
        wr(3'd2, 19);
        chk("R7 solo direct", int'(solo_pwm), 0);
        wr(3'd4, 30);
        chk("R7 pair direct", int'(pair_pwm), 1);
        wr(3'd3, 10);
        chk("R5 pair after rise", int'(pair_pwm), 0);

        // start running, armed
        cur_req = "R6";
        wr(3'd0, 3);
        lock_on = 1; have_last = 0;
        wait_count(5);
        wr(3'd3, 20);
        wr(3'd4, 35);
        wait_count(15);
        chk("R6 old pair kept", int'(pair_pwm), 1);
        wait_count(39);
        wait_count(19);
        chk("R6 new rise not yet", int'(pair_pwm), 0);
        @(negedge clk);
        chk("R6 rise at 20", int'(pair_pwm), 1);
        wait_count(34);
        chk("R6 high at 34", int'(pair_pwm), 1);
        @(negedge clk);
        chk("R6 fall at 35", int'(pair_pwm), 0);

        // R8: disarmed pair holds
        cur_req = "R8";
        wr(3'd0, 1);
        wr(3'd3, 5);
        wr(3'd4, 8);
        wait_count(39);
        wait_count(6);
        chk("R8 pair held", int'(pair_pwm), 0);
        wr(3'd0, 3);
        wait_count(39);
        wait_count(6);
        chk("R8 pair after arm", int'(pair_pwm), 1);
        wait_count(8);
        chk("R8 pair fall 8", int'(pair_pwm), 0);
        lock_on = 0;
        wr(3'd0, 1);
        wr(3'd2, 12);
        wait_count(39);
        wait_count(15);
        chk("R8 solo still loads", int'(solo_pwm), 1);
        wr(3'd0, 3);

        // R9: modulus change while running
        cur_req = "R9";
        wait_count(10);
        wr(3'd1, 29);
        repeat (20) @(negedge clk);
        chk("R9 period not cut", int'(count_o), 31);
        wait_count(39);
        @(negedge clk);
        chk("R9 wrap old mod", int'(count_o), 0);
        wait_count(29);
        @(negedge clk);
        chk("R9 new mod wrap", int'(count_o), 0);

        // R10: write on the wrap edge waits one period
        cur_req = "R10";
        wait_count(29);
        wr(3'd2, 5);
        wait_count(8);
        chk("R10 old solo used", int'(solo_pwm), 0);
        wait_count(29);
        wait_count(8);
        chk("R10 new solo next", int'(solo_pwm), 1);

        // R3: count clear
        cur_req = "R3";
        wait_count(20);
        wr(3'd5, 0);
        chk("R3 cleared", int'(count_o), 0);
        @(negedge clk);
        chk("R3 resumes", int'(count_o), 1);

        // R2: stop holds the count
        cur_req = "R2";
        wr(3'd0, 0);
        begin
            int held;
            held = int'(count_o);
            repeat (5) @(negedge clk);
            chk("R2 count held", int'(count_o), held);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule